// File: doc/BRIEF.md
# Inter-Processor Interrupt Register Block

This block lets up to eleven processing agents signal one another over a small 32-bit register bus. The bus has an address, a write strobe, write data, a read strobe and read data. Every access is a whole word. A write to the trigger word fires a one-cycle pulse on each selected outbound line. Request lines arriving from the other agents set sticky bits in a status word. Software clears those bits by writing ones to them.

A mask word decides which pending status bits reach the single interrupt output. Software never writes the mask directly. It sets mask bits through the disable word and clears them through the enable word. Every agent also has an observation output that mirrors its status bit. A read-only acknowledge word shows the levels that the other agents drive back.

The interrupt output comes from a two-state machine. In state `IRQ_QUIET` the output is low. In state `IRQ_RAISED` it is high. The transition *raise* (`IRQ_QUIET` to `IRQ_RAISED`) is taken at the clock edge where some status bit is set while its mask bit is clear. The transition *drop* (`IRQ_RAISED` to `IRQ_QUIET`) is taken at the edge where no such bit remains. Otherwise the machine holds its state.

Top module: `ipi_regblock`

## Requirements
- R1: Word offsets are: 0x00 trigger, 0x04 acknowledge, 0x10 status, 0x14 mask, 0x18 enable, 0x1C disable. The trigger, enable and disable words always read 0. A read of any other offset returns 0. Read data is combinational while the read strobe is high, and is 0 while the strobe is low.
- R2: Agent k owns one bit of every word. Agent 0 owns bit 0, agents 1–2 own bits 8–9, agents 3–6 own bits 16–19 and agents 7–10 own bits 24–27 (pattern 0x0F0F0301). All other bits read 0 and are not affected by writes.
- R3: A trigger write at clock edge N drives pulse_out[k] high for the cycle after edge N, for each agent k whose bit is set. The line is low again after edge N+1 unless a new trigger write sets it.
- R4: A request input that is high at a clock edge sets that agent's status bit at that edge. The bit stays set until software clears it.
- R5: A status write clears each implemented bit written as 1. Bits written as 0 are unchanged.
- R6: An enable write clears the mask bits written as 1. A disable write sets them. Writes to the mask word itself change nothing.
- R7: After reset the status word is 0, the mask word is 0x0F0F0301, and all pulses and the interrupt are low.
- R8: irq_o is high in the cycle after any edge at which some status bit is 1 while its mask bit is 0. It is low in the cycle after any edge at which no such bit exists.
- R9: observe_out[k] equals agent k's status bit in every cycle.
- R10: The acknowledge word shows, in agent k's bit, the level of ack_in[k] sampled at the previous clock edge.
- R11: If a request input and a status clear hit the same bit at the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| req_in | input | NUM_AGENTS (11) | Inbound request level per agent |
| ack_in | input | NUM_AGENTS (11) | Acknowledge level per agent |
| pulse_out | output | NUM_AGENTS (11) | One-cycle outbound trigger pulse per agent |
| observe_out | output | NUM_AGENTS (11) | Pending status per agent |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Directed patterns come first.
- An all-ones trigger write and a two-agent trigger write show whether pulses land on the right lanes and last exactly one cycle.
- A single request first held masked, then enabled, then cleared walks the state machine through *raise* and *drop* and separates the mask path from the status path.
- A request held high while the same bit is being cleared shows whether the set wins.
- All-ones writes to enable, disable, mask and status show whether the reserved bits really stay zero.

A long stretch of pseudo-random requests, acknowledges and bus writes is then checked cycle by cycle against the bench's behavioural model. This catches timing slips of one cycle on the pulses, the observation outputs and the interrupt.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W = 32;

    localparam logic [7:0] OFF_TRIG   = 8'h00;
    localparam logic [7:0] OFF_ACK    = 8'h04;
    localparam logic [7:0] OFF_STATUS = 8'h10;
    localparam logic [7:0] OFF_MASK   = 8'h14;
    localparam logic [7:0] OFF_ENABLE = 8'h18;
    localparam logic [7:0] OFF_DISABLE = 8'h1C;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // Bit position in a register word owned by agent idx.
    function automatic int agent_bit(input int idx);
        if (idx == 0)      return 0;
        else if (idx <= 2) return idx + 7;
        else if (idx <= 6) return idx + 13;
        else               return idx + 17;
    endfunction

endpackage

// File: rtl/ipi_trigger_gen.sv
module ipi_trigger_gen #(
    parameter int NUM_AGENTS = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fire_i,
    input  logic [NUM_AGENTS-1:0] bits_i,
    output logic [NUM_AGENTS-1:0] pulse_o
);

    logic [NUM_AGENTS-1:0] pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else if (fire_i) begin
            pulse_q <= bits_i;
        end else begin
            pulse_q <= '0;
        end
    end

    assign pulse_o = pulse_q;

    // R3: pulses last one cycle and carry the written lanes
    assert_pulse_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (pulse_o == '0));
    assert_pulse_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (pulse_o == $past(bits_i)));

endmodule

// File: rtl/ipi_status_bank.sv
module ipi_status_bank #(
    parameter int NUM_AGENTS = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_AGENTS-1:0] req_i,
    input  logic [NUM_AGENTS-1:0] ack_i,
    input  logic                  clr_wr_i,
    input  logic                  en_wr_i,
    input  logic                  dis_wr_i,
    input  logic [NUM_AGENTS-1:0] wbits_i,
    output logic [NUM_AGENTS-1:0] status_o,
    output logic [NUM_AGENTS-1:0] mask_o,
    output logic [NUM_AGENTS-1:0] ack_o
);

    logic [NUM_AGENTS-1:0] status_q, status_d;
    logic [NUM_AGENTS-1:0] mask_q, mask_d;
    logic [NUM_AGENTS-1:0] ack_q;

    always_comb begin
        status_d = status_q;
        if (clr_wr_i) begin
            status_d = status_d & ~wbits_i;
        end
        status_d = status_d | req_i;   // set wins over clear

        mask_d = mask_q;
        if (en_wr_i) begin
            mask_d = mask_d & ~wbits_i;
        end
        if (dis_wr_i) begin
            mask_d = mask_d | wbits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '1;
            ack_q    <= '0;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
            ack_q    <= ack_i;
        end
    end

    assign status_o = status_q;
    assign mask_o   = mask_q;
    assign ack_o    = ack_q;

    // R4 / R11: a request always leaves its bit set
    assert_req_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ((status_q & $past(req_i)) == $past(req_i)));
    // R5: cleared bits that were not requested read back zero
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((status_q & $past(wbits_i & ~req_i)) == '0));
    // R6: mask only moves through enable or disable writes
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_wr_i || dis_wr_i) |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/ipi_irq_fsm.sv
module ipi_irq_fsm
    import ipi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic irq_o
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pend_i)  state_d = IRQ_RAISED;  // raise
            IRQ_RAISED: if (!pend_i) state_d = IRQ_QUIET;   // drop
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_QUIET:  irq_o = 1'b0;
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ipi_regblock.sv
module ipi_regblock
    import ipi_pkg::*;
#(
    parameter int NUM_AGENTS = 11,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_we,
    input  logic [WORD_W-1:0]     bus_wdata,
    input  logic                  bus_re,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [NUM_AGENTS-1:0] req_in,
    input  logic [NUM_AGENTS-1:0] ack_in,
    output logic [NUM_AGENTS-1:0] pulse_out,
    output logic [NUM_AGENTS-1:0] observe_out,
    output logic                  irq_o
);

    localparam logic [ADDR_W-1:0] A_TRIG    = ADDR_W'(OFF_TRIG);
    localparam logic [ADDR_W-1:0] A_ACK     = ADDR_W'(OFF_ACK);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFF_ENABLE);
    localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFF_DISABLE);

    logic [NUM_AGENTS-1:0] wr_lanes;
    logic [NUM_AGENTS-1:0] status_l, mask_l, ack_l;
    logic [WORD_W-1:0]     status_w, mask_w, ack_w, impl_w;
    logic                  pending;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // lane <-> word bit mapping
    for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_lane
        localparam int BP = agent_bit(g);
        assign wr_lanes[g] = bus_wdata[BP];
    end

    always_comb begin
        status_w = '0;
        mask_w   = '0;
        ack_w    = '0;
        impl_w   = '0;
        for (int i = 0; i < NUM_AGENTS; i++) begin
            status_w[agent_bit(i)] = status_l[i];
            mask_w[agent_bit(i)]   = mask_l[i];
            ack_w[agent_bit(i)]    = ack_l[i];
            impl_w[agent_bit(i)]   = 1'b1;
        end
    end

    ipi_trigger_gen #(.NUM_AGENTS(NUM_AGENTS)) trig_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (bus_we && (bus_addr == A_TRIG)),
        .bits_i  (wr_lanes),
        .pulse_o (pulse_out)
    );

    ipi_status_bank #(.NUM_AGENTS(NUM_AGENTS)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_in),
        .ack_i    (ack_in),
        .clr_wr_i (bus_we && (bus_addr == A_STATUS)),
        .en_wr_i  (bus_we && (bus_addr == A_ENABLE)),
        .dis_wr_i (bus_we && (bus_addr == A_DISABLE)),
        .wbits_i  (wr_lanes),
        .status_o (status_l),
        .mask_o   (mask_l),
        .ack_o    (ack_l)
    );

    assign pending = |(status_l & ~mask_l);

    ipi_irq_fsm irq_fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pending),
        .irq_o  (irq_o)
    );

    assign observe_out = status_l;

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            unique case (bus_addr)
                A_ACK:    bus_rdata = ack_w;
                A_STATUS: bus_rdata = status_w;
                A_MASK:   bus_rdata = mask_w;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R8: interrupt follows pending sources one cycle later
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> irq_o);
    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> !irq_o);
    // R2: reserved bit positions never read back as one
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |-> ((bus_rdata & ~impl_w) == '0));

endmodule

// File: tb/ipi_regblock_tb_top.sv
`timescale 1ns/1ps
module ipi_regblock_tb_top;

    localparam int          N    = 11;
    localparam logic [31:0] IMPL = 32'h0F0F0301;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [N-1:0] req_in = '0;
    logic [N-1:0] ack_in = '0;
    logic [N-1:0] pulse_out, observe_out;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit live   = 0;

    always #2 clk = ~clk;

    ipi_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .req_in(req_in), .ack_in(ack_in), .pulse_out(pulse_out),
        .observe_out(observe_out), .irq_o(irq_o)
    );

    int pos [N] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27};

    function automatic logic [31:0] to_word(input logic [N-1:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < N; i++) w[pos[i]] = v[i];
        return w;
    endfunction

    function automatic logic [N-1:0] to_lanes(input logic [31:0] w);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = w[pos[i]];
        return v;
    endfunction

    // behavioural reference, word level
    logic [31:0] m_status = '0, m_mask = IMPL, m_pulse = '0, m_ack = '0;
    logic        m_irq = 1'b0;

    always @(posedge clk) begin
        logic [31:0] wm;
        wm = bus_wdata & IMPL;
        if (!rst_n) begin
            m_status = '0; m_mask = IMPL; m_pulse = '0; m_ack = '0; m_irq = 1'b0;
        end else begin
            m_irq   = ((m_status & ~m_mask) != 0);
            m_pulse = (bus_we && bus_addr == 8'h00) ? wm : '0;
            if (bus_we && bus_addr == 8'h10) m_status = m_status & ~wm;
            m_status = m_status | to_word(req_in);
            if (bus_we && bus_addr == 8'h18) m_mask = m_mask & ~wm;
            if (bus_we && bus_addr == 8'h1C) m_mask = m_mask | wm;
            m_ack = to_word(ack_in);
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h04:   return m_ack;
            8'h10:   return m_status;
            8'h14:   return m_mask;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (live) begin
            chk("R3 pulse_out", 32'(pulse_out), 32'(to_lanes(m_pulse)));
            chk("R9 observe_out", 32'(observe_out), 32'(to_lanes(m_status)));
            chk("R8 irq_o", 32'(irq_o), 32'(m_irq));
        end
    end

    task automatic drive(input logic we, input logic [7:0] a, input logic [31:0] d,
                         input logic [N-1:0] rq, input logic [N-1:0] ak);
        @(posedge clk); #1;
        bus_we = we; bus_addr = a; bus_wdata = d; bus_re = 1'b0;
        req_in = rq; ack_in = ak;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 32'h0, '0, ack_in);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(posedge clk); #1;
        bus_we = 1'b0; req_in = '0; bus_addr = a; bus_re = 1'b1;
        #0.5;
        chk(tag, bus_rdata, m_read(a));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        live = 1;
        // R7 reset state
        rd(8'h14, "R7 mask reset");
        chk("R7 mask literal", bus_rdata, 32'h0F0F0301);
        rd(8'h10, "R7 status reset");
        chk("R7 status literal", bus_rdata, 32'h0);
        // R3 trigger all lanes, then two lanes; trigger reads zero (R1)
        drive(1'b1, 8'h00, 32'hFFFF_FFFF, '0, '0);
        idle();
        chk("R3 all lanes pulse", 32'(pulse_out), 32'h7FF);
        idle();
        chk("R3 pulse cleared", 32'(pulse_out), 32'h0);
        drive(1'b1, 8'h00, 32'h0100_0100, '0, '0);
        idle();
        chk("R2 lanes 1 and 7", 32'(pulse_out), 32'h082);
        rd(8'h00, "R1 trigger reads zero");
        // R4 request on agent 3, masked
        drive(1'b0, 8'h00, 0, 11'h008, '0);
        idle();
        rd(8'h10, "R4 status set");
        chk("R4 status bit16", bus_rdata, 32'h0001_0000);
        chk("R8 masked no irq", 32'(irq_o), 32'h0);
        // R6 enable -> irq raise
        drive(1'b1, 8'h18, 32'h0001_0000, '0, '0);
        idle();
        idle();
        chk("R8 irq raised", 32'(irq_o), 32'h1);
        rd(8'h18, "R1 enable reads zero");
        rd(8'h14, "R6 mask after enable");
        // R5 zero write leaves, one clears
        drive(1'b1, 8'h10, 32'h0, '0, '0);
        rd(8'h10, "R5 zero write no effect");
        drive(1'b1, 8'h10, 32'h0001_0000, '0, '0);
        idle();
        idle();
        chk("R8 irq dropped", 32'(irq_o), 32'h0);
        rd(8'h10, "R5 status cleared");
        // R11 set wins
        drive(1'b0, 8'h00, 0, 11'h001, '0);
        drive(1'b1, 8'h10, 32'h1, 11'h001, '0);
        rd(8'h10, "R11 set wins");
        chk("R11 bit0 literal", bus_rdata & 32'h1, 32'h1);
        // R6 disable sets, mask write ignored
        drive(1'b1, 8'h1C, 32'h0001_0000, '0, '0);
        drive(1'b1, 8'h14, 32'h0, '0, '0);
        rd(8'h14, "R6 mask write ignored");
        chk("R6 mask literal", bus_rdata, 32'h0F0F0301);
        rd(8'h1C, "R1 disable reads zero");
        // R2 reserved bits
        drive(1'b1, 8'h18, 32'hFFFF_FFFF, '0, '0);
        rd(8'h14, "R2 mask all enabled");
        chk("R2 mask zero", bus_rdata, 32'h0);
        drive(1'b1, 8'h10, 32'hFFFF_FFFF, '0, '0);
        rd(8'h10, "R2 status cleared");
        // R10 acknowledge levels
        drive(1'b0, 8'h00, 0, '0, 11'h555);
        rd(8'h04, "R10 ack pattern A");
        chk("R10 ack literal", bus_rdata, to_word(11'h555));
        drive(1'b0, 8'h00, 0, '0, 11'h2AA);
        rd(8'h04, "R10 ack pattern B");
        // R1 unmapped
        rd(8'h08, "R1 unmapped 0x08");
        rd(8'h20, "R1 unmapped 0x20");
        // mixed pseudo-random traffic
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            logic [31:0] r;
            r = $urandom;
            case (r[2:0])
                3'd0: a = 8'h00; 3'd1: a = 8'h10; 3'd2: a = 8'h18;
                3'd3: a = 8'h1C; 3'd4: a = 8'h14; default: a = 8'h04;
            endcase
            drive(r[3], a, $urandom, N'((r[31:21] & {11{r[4]}})), N'($urandom));
            if (r[5]) rd(a, "R1 random read");
        end
        idle();
        idle();
        finish_run();
    end

endmodule